// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one relative pointer event into a fixed-length byte packet for a serial mouse channel. An event is made of two signed movement deltas and three button levels. The encoder captures the event, then emits the packet one byte at a time on a valid/ready byte stream that normally feeds a receive queue.

Each packet starts with a status byte, followed by the horizontal movement, then the vertical movement, then zero padding. The button bits in the status byte are active low. The vertical delta is negated before it is encoded. Both deltas are saturated symmetrically to plus or minus 127 before they are cut down to one byte. A new event is taken only while no packet is in flight.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Byte 0 is 0x87 with one bit cleared for each pressed button: left clears bit 2, middle clears bit 1 and right clears bit 0. Bits 7..3 are always 10000.
- R2: Byte 1 is the signed `mv_x` saturated to the range -127..+127 and sent as 8-bit two's complement. The code 0x80 never appears in it.
- R3: Byte 2 is the negation of the signed `mv_y`, taken in full precision and then saturated to -127..+127. For example, -32768 gives 0x7F and +32767 gives 0x81.
- R4: Every byte after byte 2 is 0x00. With the default packet length these are bytes 3 and 4.
- R5: The bytes of a packet leave in the order status, X, Y, then the zero bytes. Each packet is five bytes by default.
- R6: `ev_ready` is high only while no packet is in flight. An event offered while `ev_ready` is low is ignored and does not change the bytes of the packet in flight.
- R7: While `pk_valid` is high and `pk_ready` is low, `pk_valid` stays high and `pk_data` holds its value.
- R8: After reset, `pk_valid` is low and `ev_ready` is high.
- R9: `pk_valid` rises in the cycle after an event is accepted. `ev_ready` returns high, and `pk_valid` falls, in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder idle and able to take an event |
| mv_x | input | DELTA_W | Signed horizontal delta |
| mv_y | input | DELTA_W | Signed vertical delta (negated in the packet) |
| btn_l | input | 1 | Left button pressed |
| btn_m | input | 1 | Middle button pressed |
| btn_r | input | 1 | Right button pressed |
| pk_valid | output | 1 | Packet byte valid |
| pk_ready | input | 1 | Downstream takes the byte |
| pk_data | output | 8 | Packet byte |

## Verification
An event accepted at a clock edge shows its status byte on `pk_data` right after that edge. Each later byte appears right after the edge at which the previous one was taken. `ev_ready` comes back right after the edge that takes the last byte. The bench drives inputs and samples outputs at falling edges, so each result is read half a cycle after the rising edge that produces it. During stalls the bench also offers rogue events and compares the held byte again at every falling edge. Expected bytes come from bench functions that saturate plain integers. Fixed corner deltas are mixed with seeded random events.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;
   localparam int unsigned HDR_BTN_N = 3;
endpackage

// File: rtl/mpe_sat.sv
module mpe_sat #(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned OUT_W  = 8,
   parameter bit          NEGATE = 1'b0
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int LIM = (1 << (OUT_W - 1)) - 1;
   localparam logic signed [IN_W:0] POS = (IN_W + 1)'(LIM);
   localparam logic signed [IN_W:0] NEG = -POS;

   if (IN_W < OUT_W) begin : g_bad_width
      $error("mpe_sat: IN_W must be at least OUT_W");
   end

   logic signed [IN_W:0] ext;

   if (NEGATE) begin : g_neg
      assign ext = -$signed({din[IN_W-1], din});
   end else begin : g_pass
      assign ext = $signed({din[IN_W-1], din});
   end

   always_comb begin
      if (ext > POS)      dout = POS[OUT_W-1:0];
      else if (ext < NEG) dout = NEG[OUT_W-1:0];
      else                dout = ext[OUT_W-1:0];
   end
endmodule

// File: rtl/mpe_hdr.sv
module mpe_hdr
   import mpe_pkg::*;
(
   input  logic              left,
   input  logic              mid,
   input  logic              right,
   output logic [BYTE_W-1:0] hdr
);
   logic [BYTE_W-1:0] clr_mask;
   assign clr_mask = {{(BYTE_W - HDR_BTN_N){1'b0}}, left, mid, right};
   assign hdr      = HDR_BASE & ~clr_mask;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
   import mpe_pkg::*;
#(
   parameter int unsigned DELTA_W = 16,
   parameter int unsigned PKT_LEN = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   output logic               ev_ready,
   input  logic [DELTA_W-1:0] mv_x,
   input  logic [DELTA_W-1:0] mv_y,
   input  logic               btn_l,
   input  logic               btn_m,
   input  logic               btn_r,
   output logic               pk_valid,
   input  logic               pk_ready,
   output logic [BYTE_W-1:0]  pk_data
);
   localparam int unsigned IDX_W = $clog2(PKT_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PKT_LEN - 1);
   localparam logic [IDX_W-1:0] FIRST_PAD = IDX_W'(3);

   if (DELTA_W < BYTE_W) begin : g_bad_delta
      $error("mouse_pkt_enc: DELTA_W must be at least BYTE_W");
   end
   if (PKT_LEN < 3) begin : g_bad_len
      $error("mouse_pkt_enc: PKT_LEN must hold status, X and Y");
   end

   logic [BYTE_W-1:0] hdr_c, x_c, y_c;
   logic [BYTE_W-1:0] hdr_q, x_q, y_q;
   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;

   mpe_hdr u_hdr (.left(btn_l), .mid(btn_m), .right(btn_r), .hdr(hdr_c));

   mpe_sat #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b0)) u_sat_x (
      .din(mv_x), .dout(x_c));

   mpe_sat #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b1)) u_sat_y (
      .din(mv_y), .dout(y_c));

   assign ev_ready = !busy_q;
   assign pk_valid = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         hdr_q  <= '0;
         x_q    <= '0;
         y_q    <= '0;
      end else if (!busy_q) begin
         if (ev_valid) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            hdr_q  <= hdr_c;
            x_q    <= x_c;
            y_q    <= y_c;
         end
      end else if (pk_ready) begin
         if (idx_q == LAST_IDX) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   always_comb begin
      case (idx_q)
         IDX_W'(0): pk_data = hdr_q;
         IDX_W'(1): pk_data = x_q;
         IDX_W'(2): pk_data = y_q;
         default:   pk_data = '0;
      endcase
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid && !pk_ready |=> pk_valid && $stable(pk_data));

   assert_hdr_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_ready |=> pk_valid && (pk_data[BYTE_W-1:HDR_BTN_N] == HDR_BASE[BYTE_W-1:HDR_BTN_N]));

   assert_x_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid && idx_q == IDX_W'(1) |-> pk_data != 8'h80);

   assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid && idx_q >= FIRST_PAD |-> pk_data == '0);

   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid && pk_ready && idx_q == LAST_IDX |=> ev_ready && !pk_valid);
endmodule

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_valid = 1'b0;
   logic ev_ready;
   logic [DW-1:0] mv_x = '0, mv_y = '0;
   logic btn_l = 1'b0, btn_m = 1'b0, btn_r = 1'b0;
   logic pk_valid;
   logic pk_ready = 1'b0;
   logic [7:0] pk_data;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mouse_pkt_enc #(.DELTA_W(DW), .PKT_LEN(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
      .mv_x(mv_x), .mv_y(mv_y), .btn_l(btn_l), .btn_m(btn_m), .btn_r(btn_r),
      .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data));

   function automatic logic [7:0] sat8(int v);
      if (v > 127) return 8'h7F;
      if (v < -127) return 8'h81;
      return v[7:0];
   endfunction

   function automatic logic [7:0] hdr_exp(bit l, bit m, bit r);
      logic [7:0] h = 8'h87;
      if (l) h[2] = 1'b0;
      if (m) h[1] = 1'b0;
      if (r) h[0] = 1'b0;
      return h;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic run_event(int dx, int dy, bit l, bit m, bit r, int max_stall);
      logic [7:0] exp [5];
      exp[0] = hdr_exp(l, m, r);
      exp[1] = sat8(dx);
      exp[2] = sat8(-dy);
      exp[3] = 8'h00;
      exp[4] = 8'h00;
      mv_x = DW'(dx); mv_y = DW'(dy);
      btn_l = l; btn_m = m; btn_r = r;
      chk(ev_ready == 1'b1, "R6 idle ready", int'(ev_ready), 1);
      ev_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
      chk(pk_valid == 1'b1, "R9 valid after accept", int'(pk_valid), 1);
      for (int k = 0; k < 5; k++) begin
         int stalls = (max_stall > 0) ? int'($urandom_range(max_stall, 0)) : 0;
         string tag;
         tag = (k == 0) ? "R1 status" : (k == 1) ? "R2 X" : (k == 2) ? "R3 Y" : "R4 pad";
         chk(pk_data == exp[k], tag, int'(pk_data), int'(exp[k]));
         for (int s = 0; s < stalls; s++) begin
            pk_ready = 1'b0;
            ev_valid = 1'b1;
            mv_x = 16'h0005; mv_y = 16'h0009;
            btn_l = ~l; btn_m = ~m; btn_r = ~r;
            @(negedge clk);
            chk(pk_valid && pk_data == exp[k], "R7 hold on stall", int'(pk_data), int'(exp[k]));
            chk(ev_ready == 1'b0, "R6 busy not ready", int'(ev_ready), 0);
         end
         ev_valid = 1'b0;
         pk_ready = 1'b1;
         @(negedge clk);
         pk_ready = 1'b0;
         if (k < 4)
            chk(pk_valid == 1'b1, "R5 next byte present", int'(pk_valid), 1);
      end
      chk(ev_ready == 1'b1 && pk_valid == 1'b0, "R9 release after last",
          int'({ev_ready, pk_valid}), 2);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(pk_valid == 1'b0, "R8 reset valid", int'(pk_valid), 0);
      chk(ev_ready == 1'b1, "R8 reset ready", int'(ev_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pk_valid == 1'b0 && ev_ready == 1'b1, "R8 after reset", int'({pk_valid, ev_ready}), 1);
      run_event(0, 0, 0, 0, 0, 0);
      run_event(127, -127, 1, 0, 0, 1);
      run_event(128, 128, 0, 1, 0, 2);
      run_event(-128, -128, 0, 0, 1, 0);
      run_event(-32768, -32768, 1, 1, 1, 3);
      run_event(32767, 32767, 1, 0, 1, 1);
      run_event(-1, 1, 0, 1, 1, 0);
      for (int i = 0; i < 300; i++) begin
         int dx, dy;
         logic [2:0] b;
         dx = int'($signed(16'($urandom)));
         dy = int'($signed(16'($urandom)));
         if ($urandom_range(1, 0) == 1) dx = dx % 200;
         if ($urandom_range(1, 0) == 1) dy = dy % 200;
         b = 3'($urandom);
         run_event(dx, dy, b[2], b[1], b[0], 2);
         if ($urandom_range(1, 0) == 1) @(negedge clk);
      end
      summary();
   end
endmodule